// File: doc/BRIEF.md
# Complementary PWM Timer with Dead Time

This block is a 16-bit up-counting timer that produces a complementary pair of pulse-width-modulated outputs. The counter runs from 1 up to a programmed reload value and then starts again at 1. A programmed match value splits each period into two parts. The primary output changes level when the count reaches the match value, and it returns to its starting level when the period restarts. The second output is always the inverse of the primary.

Before either output goes from inactive to active, a programmable dead time is inserted. Falling edges pass straight through. As a result, one output has always deasserted before its partner asserts.

Software sets the timer up through a byte-wide write port. Match and reload are each written as two bytes. These two values are held in staging registers and are copied into the live compare registers only at a period boundary, or at any time while the timer is off. A single-cycle interrupt pulse marks each period restart.

Top module: `cpwm_timer`

## Requirements
- R1: While the enable bit is clear, both outputs are low, no interrupt is produced and the count is held at 1. After reset, all outputs are low.
- R2: With the polarity bit at 0, the primary output is low while the count is below the match value and high from the match value up to the reload value.
- R3: With the polarity bit at 1, the primary output is high while the count is below the match value and low from the match value up to the reload value.
- R4: The complementary output is the inverse of the primary output before dead time is applied. If the match value exceeds the reload value, the primary output never changes level.
- R5: In the tick after the count equals the reload value, the count returns to 1. The interrupt is high for exactly one clock, in the cycle right after that event. One period lasts reload × prescale clocks.
- R6: The counter advances once every 2^S clocks, where S is the 3-bit prescale field (S = 0 to 7).
- R7: Each rising edge of either output is delayed by D clocks, where D is the dead-time register. Falling edges are not delayed. When D = 0, the outputs follow the raw signals directly. The two outputs are never high together.
- R8: A dead-time value above 128 behaves as 128.
- R9: The output pair takes its starting polarity level in the first cycle after the enable write.
- R10: Writes to match or reload while the timer runs have no effect until the next reload event.
- R11: Register addresses (wr_addr) are: 0 match high byte, 1 match low byte, 2 reload high byte, 3 reload low byte, 4 control, 5 dead time. The control byte holds enable in bit 7, polarity in bit 6 and the prescale field in bits 2:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 8 | Register write data |
| pwm_o | output | 1 | Primary PWM output |
| pwm_n_o | output | 1 | Complementary PWM output |
| irq_o | output | 1 | One-clock pulse on each reload |

## Verification
The hardest case to reach from the ports is a match-value write that lands in the middle of a running period. The write must be seen to have no effect until the next reload, and it must then move the edge in the following period.

The bench reaches this case in a directed test that counts clocks from the enable edge. It writes a new match value while the primary output is already active. It then checks that the output stays active for the rest of that period, and that the output's rise in the next period is delayed by both the new match value and the dead time.

Steady-state duty and dead-time arithmetic, including the clamp at 128 and the largest prescale, are covered by counting high cycles over exactly one period for each table entry.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;
   typedef enum logic [2:0] {
      ADR_MATCH_HI  = 3'd0,
      ADR_MATCH_LO  = 3'd1,
      ADR_RELOAD_HI = 3'd2,
      ADR_RELOAD_LO = 3'd3,
      ADR_CTRL      = 3'd4,
      ADR_DEAD      = 3'd5
   } cpwm_addr_e;

   localparam int CTRL_EN_BIT  = 7;
   localparam int CTRL_POL_BIT = 6;
endpackage

// File: rtl/cpwm_prescale.sv
module cpwm_prescale #(
   parameter int PS_W = 3
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        run,
   input  logic [(PS_W>0?PS_W:1)-1:0]  sel,
   output logic                        tick
);
   localparam int DIV_W = (PS_W > 0) ? (2**PS_W) - 1 : 1;

   generate
      if (PS_W == 0) begin : g_nodiv
         logic unused_sel;
         assign unused_sel = ^sel;
         assign tick = run;
      end else begin : g_div
         logic [DIV_W-1:0] div_q;
         logic [DIV_W-1:0] mask;
         // terminal count is 2^sel - 1
         assign mask = ~({DIV_W{1'b1}} << sel);
         assign tick = run && (div_q == mask);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       div_q <= '0;
            else if (!run)    div_q <= '0;
            else if (tick)    div_q <= '0;
            else              div_q <= div_q + 1'b1;
         end
      end
   endgenerate
endmodule

// File: rtl/cpwm_core.sv
module cpwm_core #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             tick,
   input  logic             pol,
   input  logic [CNT_W-1:0] match_stage,
   input  logic [CNT_W-1:0] reload_stage,
   output logic             raw_p,
   output logic             raw_n,
   output logic             irq,
   output logic [CNT_W-1:0] cnt,
   output logic             reload_evt,
   output logic [CNT_W-1:0] match_live
);
   localparam logic [CNT_W-1:0] START = CNT_W'(1);

   logic [CNT_W-1:0] reload_live;
   logic             past_match;

   assign reload_evt = tick && (cnt == reload_live);
   assign past_match = (cnt >= match_live);
   assign raw_p      = en &  (pol ^ past_match);
   assign raw_n      = en & ~(pol ^ past_match);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt         <= START;
         match_live  <= '0;
         reload_live <= '0;
         irq         <= 1'b0;
      end else begin
         irq <= en && reload_evt;
         if (!en) begin
            cnt         <= START;
            match_live  <= match_stage;
            reload_live <= reload_stage;
         end else if (reload_evt) begin
            cnt         <= START;
            match_live  <= match_stage;
            reload_live <= reload_stage;
         end else if (tick) begin
            cnt <= cnt + 1'b1;
         end
      end
   end
endmodule

// File: rtl/cpwm_deadband.sv
module cpwm_deadband #(
   parameter int DB_W   = 8,
   parameter int DB_MAX = 128
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            raw,
   input  logic [DB_W-1:0] dly,
   output logic            out
);
   localparam logic [DB_W-1:0] LIMIT = DB_W'(DB_MAX);

   logic [DB_W-1:0] dly_c;
   logic [DB_W-1:0] held_q;

   assign dly_c = (dly > LIMIT) ? LIMIT : dly;
   assign out   = raw && (held_q >= dly_c);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              held_q <= '0;
      else if (!raw)           held_q <= '0;
      else if (held_q < dly_c) held_q <= held_q + 1'b1;
   end
endmodule

// File: rtl/cpwm_timer.sv
module cpwm_timer #(
   parameter int CNT_W  = 16,
   parameter int PS_W   = 3,
   parameter int DB_W   = 8,
   parameter int DB_MAX = 128
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_en,
   input  logic [2:0] wr_addr,
   input  logic [7:0] wr_data,
   output logic       pwm_o,
   output logic       pwm_n_o,
   output logic       irq_o
);
   import cpwm_pkg::*;

   localparam int PSW = (PS_W > 0) ? PS_W : 1;
   localparam int HI_W = CNT_W - 8;

   generate
      if (CNT_W <= 8 || CNT_W > 16) begin : g_bad_cnt
         $error("cpwm_timer: CNT_W must be 9..16");
      end
      if (PS_W > 3) begin : g_bad_ps
         $error("cpwm_timer: PS_W must be 0..3");
      end
      if (DB_MAX >= 2**DB_W) begin : g_bad_db
         $error("cpwm_timer: DB_MAX must fit in DB_W bits");
      end
   endgenerate

   logic [CNT_W-1:0] match_stage, reload_stage;
   logic             ctl_en, ctl_pol;
   logic [PSW-1:0]   ctl_sel;
   logic [DB_W-1:0]  dead_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         match_stage  <= '0;
         reload_stage <= '0;
         ctl_en       <= 1'b0;
         ctl_pol      <= 1'b0;
         ctl_sel      <= '0;
         dead_q       <= '0;
      end else if (wr_en) begin
         case (wr_addr)
            ADR_MATCH_HI:  match_stage[CNT_W-1:8]  <= wr_data[HI_W-1:0];
            ADR_MATCH_LO:  match_stage[7:0]        <= wr_data;
            ADR_RELOAD_HI: reload_stage[CNT_W-1:8] <= wr_data[HI_W-1:0];
            ADR_RELOAD_LO: reload_stage[7:0]       <= wr_data;
            ADR_CTRL: begin
               ctl_en  <= wr_data[CTRL_EN_BIT];
               ctl_pol <= wr_data[CTRL_POL_BIT];
               ctl_sel <= wr_data[PSW-1:0];
            end
            ADR_DEAD:      dead_q <= DB_W'(wr_data);
            default: ;
         endcase
      end
   end

   logic             tick;
   logic             raw_p, raw_n;
   logic [CNT_W-1:0] core_cnt, core_match_live;
   logic             core_reload_evt;

   cpwm_prescale #(.PS_W(PS_W)) i_prescale (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (ctl_en),
      .sel  (ctl_sel),
      .tick (tick)
   );

   cpwm_core #(.CNT_W(CNT_W)) i_core (
      .clk         (clk),
      .rst_n       (rst_n),
      .en          (ctl_en),
      .tick        (tick),
      .pol         (ctl_pol),
      .match_stage (match_stage),
      .reload_stage(reload_stage),
      .raw_p       (raw_p),
      .raw_n       (raw_n),
      .irq         (irq_o),
      .cnt         (core_cnt),
      .reload_evt  (core_reload_evt),
      .match_live  (core_match_live)
   );

   logic [1:0] raw_pair, out_pair;
   assign raw_pair = {raw_n, raw_p};

   genvar ch;
   generate
      for (ch = 0; ch < 2; ch++) begin : g_dead
         cpwm_deadband #(.DB_W(DB_W), .DB_MAX(DB_MAX)) i_db (
            .clk  (clk),
            .rst_n(rst_n),
            .raw  (raw_pair[ch]),
            .dly  (dead_q),
            .out  (out_pair[ch])
         );
      end
   endgenerate

   assign pwm_o   = out_pair[0];
   assign pwm_n_o = out_pair[1];
endmodule

// File: rtl/cpwm_timer_chk.sv
module cpwm_timer_chk #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             en,
   input logic             pwm,
   input logic             pwm_n,
   input logic             irq,
   input logic             raw_p,
   input logic [CNT_W-1:0] cnt,
   input logic             reload_evt,
   input logic [CNT_W-1:0] match_live
);
   // R1
   idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en |-> (!pwm && !pwm_n));

   // R1
   idle_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !irq);

   // R7
   no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(pwm && pwm_n));

   // R7
   fall_now_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(raw_p) |-> !pwm);

   // R5
   restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reload_evt |=> (cnt == CNT_W'(1)));

   // R5
   irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> $past(reload_evt));

   // R10
   match_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !reload_evt) |=> $stable(match_live));
endmodule

bind cpwm_timer cpwm_timer_chk #(.CNT_W(CNT_W)) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .en        (ctl_en),
   .pwm       (pwm_o),
   .pwm_n     (pwm_n_o),
   .irq       (irq_o),
   .raw_p     (raw_p),
   .cnt       (core_cnt),
   .reload_evt(core_reload_evt),
   .match_live(core_match_live)
);

// File: tb/test_cpwm_timer.sv
`timescale 1ns/1ps
module test_cpwm_timer;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [2:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic       pwm_o, pwm_n_o, irq_o;

   int tests = 0;
   int fails = 0;

   always #2 clk = ~clk;

   cpwm_timer i_cpwm_timer (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .pwm_o(pwm_o), .pwm_n_o(pwm_n_o), .irq_o(irq_o)
   );

   typedef struct packed {
      logic [15:0] match;
      logic [15:0] reload;
      logic        pol;
      logic [2:0]  sel;
      logic [7:0]  dead;
      logic [15:0] exp_p;
      logic [15:0] exp_n;
   } vec_t;

   // expected high-cycle counts per period, worked out from R2-R8
   localparam vec_t VEC [7] = '{
      '{16'd3,  16'd5,  1'b0, 3'd0, 8'd0,   16'd3,   16'd2},
      '{16'd3,  16'd5,  1'b1, 3'd0, 8'd0,   16'd2,   16'd3},
      '{16'd2,  16'd6,  1'b0, 3'd1, 8'd3,   16'd7,   16'd0},
      '{16'd4,  16'd8,  1'b1, 3'd0, 8'd2,   16'd1,   16'd3},
      '{16'd30, 16'd40, 1'b0, 3'd3, 8'd130, 16'd0,   16'd104},
      '{16'd9,  16'd5,  1'b0, 3'd0, 8'd0,   16'd0,   16'd5},
      '{16'd2,  16'd3,  1'b0, 3'd7, 8'd0,   16'd256, 16'd128}
   };

   function automatic string vtag(int i);
      case (i)
         0: return "R2 R6 vec0";
         1: return "R3 vec1";
         2: return "R6 R7 vec2";
         3: return "R3 R7 vec3";
         4: return "R8 vec4";
         5: return "R4 vec5";
         default: return "R6 vec6";
      endcase
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 reset pwm", int'(pwm_o), 0);
      chk("R1 reset pwm_n", int'(pwm_n_o), 0);
      chk("R1 reset irq", int'(irq_o), 0);

      // R9 starting level, R11 map
      wr(3'd0, 8'd0); wr(3'd1, 8'd20); wr(3'd2, 8'd0); wr(3'd3, 8'd40);
      wr(3'd5, 8'd0);
      wr(3'd4, 8'hC0);
      chk("R9 pol1 pwm", int'(pwm_o), 1);
      chk("R9 pol1 pwm_n", int'(pwm_n_o), 0);
      wr(3'd4, 8'h00);
      begin
         int hi = 0;
         for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            hi += int'(pwm_o) + int'(pwm_n_o) + int'(irq_o);
         end
         chk("R1 disabled quiet", hi, 0);
      end
      wr(3'd4, 8'h80);
      chk("R9 pol0 pwm", int'(pwm_o), 0);
      chk("R9 pol0 pwm_n", int'(pwm_n_o), 1);
      wr(3'd4, 8'h00);

      // R7 / R10 / R5 directed timing, dead time 5
      wr(3'd5, 8'd5);
      wr(3'd4, 8'h80);
      for (int k = 2; k <= 85; k++) begin
         @(negedge clk);
         if (k == 22) begin wr_en = 1'b1; wr_addr = 3'd1; wr_data = 8'd35; end
         if (k == 23) wr_en = 1'b0;
         if (k == 5)  chk("R7 pwm_n still delayed", int'(pwm_n_o), 0);
         if (k == 6)  chk("R7 pwm_n rises after 5", int'(pwm_n_o), 1);
         if (k == 19) chk("R7 pwm_n before match", int'(pwm_n_o), 1);
         if (k == 20) chk("R7 pwm_n falls undelayed", int'(pwm_n_o), 0);
         if (k == 20) chk("R2 pwm delayed at match", int'(pwm_o), 0);
         if (k == 24) chk("R7 pwm still delayed", int'(pwm_o), 0);
         if (k == 25) chk("R7 pwm rises after 5", int'(pwm_o), 1);
         if (k == 30) chk("R10 match write held", int'(pwm_o), 1);
         if (k == 40) chk("R5 irq before reload", int'(irq_o), 0);
         if (k == 41) chk("R5 irq pulse", int'(irq_o), 1);
         if (k == 41) chk("R5 pwm low at restart", int'(pwm_o), 0);
         if (k == 42) chk("R5 irq one cycle", int'(irq_o), 0);
         if (k == 74) chk("R10 pwm_n before new match", int'(pwm_n_o), 1);
         if (k == 75) chk("R10 pwm_n at new match", int'(pwm_n_o), 0);
         if (k == 79) chk("R10 pwm before new edge", int'(pwm_o), 0);
         if (k == 80) chk("R10 pwm at new edge", int'(pwm_o), 1);
      end
      wr(3'd4, 8'h00);
      @(negedge clk);
      chk("R1 disable drops outputs", int'(pwm_o) + int'(pwm_n_o), 0);

      // table of steady-state periods
      for (int v = 0; v < 7; v++) begin
         int period, hp, hn, ni, ov;
         period = int'(VEC[v].reload) << VEC[v].sel;
         wr(3'd4, 8'h00);
         wr(3'd0, VEC[v].match[15:8]);  wr(3'd1, VEC[v].match[7:0]);
         wr(3'd2, VEC[v].reload[15:8]); wr(3'd3, VEC[v].reload[7:0]);
         wr(3'd5, VEC[v].dead);
         wr(3'd4, {1'b1, VEC[v].pol, 3'b000, VEC[v].sel});
         repeat (3 * period) @(negedge clk);
         hp = 0; hn = 0; ni = 0; ov = 0;
         for (int c = 0; c < period; c++) begin
            @(negedge clk);
            hp += int'(pwm_o);
            hn += int'(pwm_n_o);
            ni += int'(irq_o);
            ov += int'(pwm_o & pwm_n_o);
         end
         chk({vtag(v), " pwm high"}, hp, int'(VEC[v].exp_p));
         chk({vtag(v), " R4 pwm_n high"}, hn, int'(VEC[v].exp_n));
         chk({vtag(v), " R5 irq per period"}, ni, 1);
         chk({vtag(v), " R7 overlap"}, ov, 0);
      end

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule